// File: doc/BRIEF.md
# Triggered Dual-Edge Event Frame Serializer

This block sends one fixed-length event record per accepted trigger over a single serial data line. The record is built from a fixed sync byte (8'hA5) and a 2-bit header (2'b10). It also carries a 5-bit running trigger number, the 9-bit identifier of the chip, the 64 hit bits presented by the capture logic, and an 8-bit zero trailer. That makes 96 bits, sent most significant bit first. Two bits leave per clock cycle, one in each half of the cycle. At a 50 MHz clock this gives 100 Mbit/s and 960 ns per record.

The forwarded serial clock and the data line stay low while no record is being sent, so the readout path stays quiet between triggers. The capture logic raises `snap_valid` for one cycle per trigger and holds the hit pattern until `ack`. A trigger that arrives during a record is counted. The first such trigger is queued and its record follows with no gap. Any further trigger in the same record only advances the count.

Top module: `evt_frame_ser`

## Requirements
- R1: The record is, from the first bit sent to the last: 8'hA5, 2'b10, trigger number (5 bits), `chip_id` (9 bits), `snap_data` bit 63 down to bit 0, then eight zeros.
- R2: Each cycle carries two consecutive record bits. The earlier bit is on `ser_data` while `ser_clk` is high and the later bit while `ser_clk` is low. `ser_clk` gives 48 high pulses per record, and the first pulse starts one clock edge after the edge that started the record.
- R3: Outside a record, `ser_clk` and `ser_data` are held at 0, including from reset onward.
- R4: `busy` rises on the clock edge that samples an accepted trigger and stays high for exactly 48 cycles.
- R5: `ack` is a one-cycle pulse in the 48th (last) busy cycle of each record and is 0 otherwise.
- R6: The first trigger after reset carries number 0. Every `snap_valid` cycle advances the count by one, wrapping from 31 to 0.
- R7: The first trigger sampled while a record is in progress starts the next record at the end of the current one with no idle cycle, and that record carries this trigger's own number. Later triggers during the same record advance the count but produce no record.
- R8: `snap_data` and `chip_id` are sampled on the edge that starts a record. Changes after that edge do not alter the record.
- R9: Active-low asynchronous `rst_n` aborts any record, clears the count and any queued trigger, and forces `busy`, `ack`, `ser_clk` and `ser_data` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock (both phases carry data) |
| rst_n | input | 1 | Asynchronous active-low reset |
| snap_valid | input | 1 | One-cycle trigger strobe from the capture logic |
| snap_data | input | 64 | Hit pattern, held until `ack` |
| chip_id | input | 9 | Chip identifier placed in every record |
| busy | output | 1 | A record is in progress |
| ack | output | 1 | Last cycle of a record; the hit pattern may be released |
| ser_clk | output | 1 | Forwarded clock, running only during a record |
| ser_data | output | 1 | Serial record data, two bits per cycle |

## Verification
A corrupted shift register or a misloaded record appears at once on `ser_data` as a wrong bit in the 96-bit word the bench reassembles. A pair-ordering fault swaps neighbouring bits in the very first cycle. A wrong cycle counter shows within one record, as a missing or extra `ser_clk` pulse, a misplaced `ack`, or `busy` ending early. A broken trigger counter or queue shows up in the trigger-number field of the next record, which makes it visible one record later at most.

// File: rtl/evt_frame_pkg.sv
`timescale 1ns/1ps
package evt_frame_pkg;

  // Cycles needed to send a record when two bits leave per cycle.
  function automatic int pair_cycles(input int bits);
    return (bits + 1) / 2;
  endfunction

  // Width of a counter that must reach n-1.
  function automatic int count_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/evt_trig_ctl.sv
`timescale 1ns/1ps
module evt_trig_ctl #(
  parameter int TID_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic             slot_free,
  output logic             start,
  output logic [TID_W-1:0] start_id
);

  logic [TID_W-1:0] trig_cnt;
  logic             pend;
  logic [TID_W-1:0] pend_id;

  // A queued trigger has priority over a new one at a free slot.
  assign start    = slot_free && (pend || trig);
  assign start_id = pend ? pend_id : trig_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_cnt <= '0;
      pend     <= 1'b0;
      pend_id  <= '0;
    end else begin
      if (trig) trig_cnt <= trig_cnt + TID_W'(1);
      if (start) begin
        pend    <= pend && trig;
        pend_id <= trig_cnt;
      end else if (trig && !pend) begin
        pend    <= 1'b1;
        pend_id <= trig_cnt;
      end
    end
  end

  AST_ID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !trig |=> $stable(trig_cnt)); // R6

  AST_ID_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> (trig_cnt == $past(trig_cnt) + TID_W'(1))); // R6

endmodule

// File: rtl/evt_shift_core.sv
`timescale 1ns/1ps
module evt_shift_core #(
  parameter int FRAME_W = 96
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [FRAME_W-1:0] frame_in,
  output logic               active,
  output logic               last,
  output logic [1:0]         pair
);
  import evt_frame_pkg::*;

  localparam int CYC   = pair_cycles(FRAME_W);
  localparam int CNT_W = count_width(CYC);

  logic [FRAME_W-1:0] sh;
  logic [CNT_W-1:0]   cyc_cnt;

  assign last = active && (cyc_cnt == CNT_W'(CYC - 1));
  assign pair = sh[FRAME_W-1 -: 2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh      <= '0;
      cyc_cnt <= '0;
      active  <= 1'b0;
    end else if (start) begin
      sh      <= frame_in;
      cyc_cnt <= '0;
      active  <= 1'b1;
    end else if (active) begin
      sh      <= sh << 2;
      cyc_cnt <= cyc_cnt + CNT_W'(1);
      if (last) active <= 1'b0;
    end
  end

  AST_NO_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && active) |-> last); // R7

  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !last); // R5

  AST_SPAN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> (cyc_cnt == '0)); // R4

  AST_SPAN_END: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> (!active || cyc_cnt == '0)); // R4

endmodule

// File: rtl/evt_ddr_out.sv
`timescale 1ns/1ps
module evt_ddr_out (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  logic [1:0] pair,
  output logic       ser_clk,
  output logic       ser_data
);

  logic [1:0] hold;
  logic       clk_en;

  // One register stage so each pair occupies a whole high+low cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold <= 2'b00;
    else        hold <= active ? pair : 2'b00;
  end

  // Enable changes only while clk is low, so the gated clock has no runt pulse.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) clk_en <= 1'b0;
    else        clk_en <= active;
  end

  assign ser_clk  = clk && clk_en;
  assign ser_data = clk ? hold[1] : hold[0];

  AST_QUIET_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (hold == 2'b00)); // R3

endmodule

// File: rtl/evt_frame_ser.sv
`timescale 1ns/1ps
module evt_frame_ser #(
  parameter int              HIT_W    = 64,
  parameter int              CID_W    = 9,
  parameter int              TID_W    = 5,
  parameter int              SYNC_W   = 8,
  parameter int              HDR_W    = 2,
  parameter int              EOF_W    = 8,
  parameter logic [SYNC_W-1:0] SYNC_PAT = 8'hA5,
  parameter logic [HDR_W-1:0]  HDR_PAT  = 2'b10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             snap_valid,
  input  logic [HIT_W-1:0] snap_data,
  input  logic [CID_W-1:0] chip_id,
  output logic             busy,
  output logic             ack,
  output logic             ser_clk,
  output logic             ser_data
);

  localparam int FRAME_W = SYNC_W + HDR_W + TID_W + CID_W + HIT_W + EOF_W;

  function automatic logic [FRAME_W-1:0] pack_frame(
    input logic [TID_W-1:0] id,
    input logic [CID_W-1:0] chip,
    input logic [HIT_W-1:0] hits
  );
    return {SYNC_PAT, HDR_PAT, id, chip, hits, {EOF_W{1'b0}}};
  endfunction

  logic               start;
  logic [TID_W-1:0]   start_id;
  logic               active;
  logic               last;
  logic               slot_free;
  logic [1:0]         pair;
  logic [FRAME_W-1:0] frame_word;

  assign slot_free  = !active || last;
  assign frame_word = pack_frame(start_id, chip_id, snap_data);

  evt_trig_ctl #(.TID_W(TID_W)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig      (snap_valid),
    .slot_free (slot_free),
    .start     (start),
    .start_id  (start_id)
  );

  evt_shift_core #(.FRAME_W(FRAME_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .frame_in (frame_word),
    .active   (active),
    .last     (last),
    .pair     (pair)
  );

  evt_ddr_out u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (active),
    .pair     (pair),
    .ser_clk  (ser_clk),
    .ser_data (ser_data)
  );

  assign busy = active;
  assign ack  = last;

  AST_ACK_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> busy); // R5

endmodule

// File: tb/evt_frame_ser_test.sv
`timescale 1ns/1ps
module evt_frame_ser_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        snap_valid = 1'b0;
  logic [63:0] snap_data = '0;
  logic [8:0]  chip_id = '0;
  logic        busy, ack, ser_clk, ser_data;

  int total = 0;
  int bad = 0;
  int exp_id = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  evt_frame_ser uut (
    .clk(clk), .rst_n(rst_n), .snap_valid(snap_valid), .snap_data(snap_data),
    .chip_id(chip_id), .busy(busy), .ack(ack), .ser_clk(ser_clk), .ser_data(ser_data)
  );

  function automatic logic [95:0] exp_frame(input int id, input logic [8:0] chip,
                                            input logic [63:0] hits);
    logic [95:0] f;
    f = '0;
    f[95:88] = 8'hA5;
    f[87:86] = 2'b10;
    f[85:81] = 5'(id % 32);
    f[80:72] = chip;
    f[71:8]  = hits;
    return f;
  endfunction

  task automatic check(input bit ok, input string req, input logic [95:0] act,
                       input logic [95:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Starts a record: strobe sampled on the next edge, then hit data scrambled (R8).
  task automatic fire(input logic [63:0] hits);
    @(negedge clk);
    snap_data  = hits;
    snap_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    snap_valid = 1'b0;
    snap_data  = ~hits;
    check(busy === 1'b1, "R4 busy after start", 96'(busy), 96'd1);
  endtask

  // Collects one record from the edge after its start edge.
  task automatic rx_frame(output logic [95:0] f, output int cerr, output int berr,
                          output int aerr);
    f = '0; cerr = 0; berr = 0; aerr = 0;
    for (int k = 0; k < 48; k++) begin
      @(posedge clk); #1;
      f[95-2*k] = ser_data;
      if (ser_clk !== 1'b1) cerr++;
      if (k < 47 && busy !== 1'b1) berr++;
      if (ack !== (k == 46)) aerr++;
      @(negedge clk); #1;
      f[94-2*k] = ser_data;
      if (ser_clk !== 1'b0) cerr++;
    end
  endtask

  task automatic check_frame(input logic [95:0] exp, input string tag);
    logic [95:0] f;
    int ce, be, ae;
    rx_frame(f, ce, be, ae);
    check(f === exp, {"R1 R8 record ", tag}, f, exp);
    check(ce == 0, {"R2 clock phases ", tag}, 96'(ce), 96'd0);
    check(be == 0, {"R4 busy span ", tag}, 96'(be), 96'd0);
    check(ae == 0, {"R5 ack position ", tag}, 96'(ae), 96'd0);
  endtask

  task automatic check_idle(input int cycles, input string tag);
    int err = 0;
    for (int k = 0; k < cycles; k++) begin
      @(posedge clk); #1;
      if (ser_clk !== 1'b0 || ser_data !== 1'b0 || busy !== 1'b0 || ack !== 1'b0) err++;
      @(negedge clk); #1;
      if (ser_clk !== 1'b0 || ser_data !== 1'b0) err++;
    end
    check(err == 0, {"R3 idle quiet ", tag}, 96'(err), 96'd0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    #12;
    check(busy === 1'b0 && ack === 1'b0, "R9 reset outputs", 96'({busy, ack}), 96'd0);
    check(ser_clk === 1'b0 && ser_data === 1'b0, "R9 reset lines",
          96'({ser_clk, ser_data}), 96'd0);
    @(negedge clk);
    rst_n = 1'b1;
    exp_id = 0;
    check_idle(5, "after reset");
  endtask

  task automatic t_patterns;
    logic [63:0] pats [4];
    pats[0] = 64'h0;
    pats[1] = 64'hFFFF_FFFF_FFFF_FFFF;
    pats[2] = 64'h8000_0000_0000_0001;
    pats[3] = 64'h0123_4567_89AB_CDEF;
    chip_id = 9'h1A5;
    for (int i = 0; i < 4; i++) begin
      fire(pats[i]);
      check_frame(exp_frame(exp_id, chip_id, pats[i]), "pattern");
      exp_id++;
      check_idle(2, "between records");
    end
    chip_id = 9'h000;
    fire(64'hDEAD_BEEF_0000_5555);
    check_frame(exp_frame(exp_id, 9'h000, 64'hDEAD_BEEF_0000_5555), "chip zero");
    exp_id++;
  endtask

  task automatic t_wrap;
    chip_id = 9'h0F3;
    for (int i = 0; i < 30; i++) begin
      fire(64'(i) * 64'h0101_0101_0101_0101);
      check_frame(exp_frame(exp_id, chip_id, 64'(i) * 64'h0101_0101_0101_0101),
                  (exp_id % 32 == 0) ? "R6 wrap to zero" : "R6 id step");
      exp_id++;
    end
  endtask

  task automatic t_pending;
    int id_a, id_b;
    chip_id = 9'h155;
    id_a = exp_id;
    fire(64'hAAAA_0000_AAAA_0000);
    id_b = id_a + 1;
    fork
      check_frame(exp_frame(id_a, chip_id, 64'hAAAA_0000_AAAA_0000), "R7 first");
      begin
        repeat (9) @(negedge clk);
        snap_valid = 1'b1; snap_data = 64'h1357_9BDF_2468_ACE0;
        @(negedge clk); snap_valid = 1'b0;
        repeat (6) @(negedge clk);
        snap_valid = 1'b1;
        @(negedge clk); snap_valid = 1'b0;
      end
    join
    check_frame(exp_frame(id_b, chip_id, 64'h1357_9BDF_2468_ACE0), "R7 queued");
    check_idle(3, "R7 extra trigger dropped");
    exp_id = id_a + 3;
    fire(64'h0F0F_0F0F_F0F0_F0F0);
    check_frame(exp_frame(exp_id, chip_id, 64'h0F0F_0F0F_F0F0_F0F0), "R7 count kept");
    exp_id++;
  endtask

  task automatic t_abort;
    fire(64'hFFFF_0000_FFFF_0000);
    repeat (10) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(busy === 1'b0 && ser_clk === 1'b0, "R9 abort", 96'({busy, ser_clk}), 96'd0);
    @(negedge clk);
    rst_n = 1'b1;
    exp_id = 0;
    check_idle(3, "R9 after abort");
    chip_id = 9'h1FF;
    fire(64'h1111_2222_3333_4444);
    check_frame(exp_frame(0, chip_id, 64'h1111_2222_3333_4444), "R9 id restart");
  endtask

  initial begin
    t_reset();
    t_patterns();
    t_wrap();
    t_pending();
    t_abort();
    check_idle(4, "final");
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule